// File: doc/BRIEF.md
# Host-to-memory word FIFO DMA bridge

This block connects a 16-bit host register interface to a DMA channel that writes into memory. The host arms a transfer by setting an enable bit and loading a word length, then feeds words one at a time through a data port into a small FIFO. On the DMA side, software programs a destination address, a transfer count, a channel-mode register and a global enable. When the FIFO holds a whole group of four words and the channel is armed, the bridge drains the FIFO to a 16-bit memory write port. It writes one word per accepted handshake and steps the destination address by two bytes per word.

The host and the DMA channel each track completion on their own side. The host length counts down and clears the enable bit when it reaches zero. The DMA transfer count counts down and raises an end flag in the channel-mode register when it reaches zero. While a burst is running, the host is held off through a ready signal.

Top module: `dreq_bridge`

## Requirements
- R1: After reset, xferEnable, modeBit and fifoFull are 0, lengthLeft, xferCount and chanCtrl are 0, memValid is 0 and hostReady is 1.
- R2: A host write to the control register (hostSel 0) loads xferEnable from data bit 2 and modeBit from data bit 0. It leaves fifoFull unchanged.
- R3: A host write to the length register (hostSel 1) stores the written value with bits 1 and 0 forced to zero.
- R4: A host write to the data port (hostSel 2) is ignored while xferEnable is 0.
- R5: fifoFull is 1 exactly when the FIFO holds DEPTH words. Data-port writes made while it is full are discarded.
- R6: A drain starts only when the FIFO word count is a nonzero multiple of four, chanCtrl bits [1:0] equal 2'b01 and bit 0 of the global enable (cfgSel 4) is 1.
- R7: In a drain, the FIFO words go out in write order, one per cycle in which memValid and memReady are both high. Each word goes to memAddr, the destination address. Each accepted word adds 2 to the destination and subtracts 1 from xferCount and from lengthLeft (lengthLeft stops at 0). memValid and memAddr hold while memReady is low.
- R8: A drain ends when the FIFO has been emptied or xferCount is 0. The FIFO is then empty and fifoFull is 0, and any words not sent are dropped.
- R9: If lengthLeft is 0 when a drain ends, xferEnable clears.
- R10: If xferCount is 0 when a drain ends, chanCtrl bit 1 is set.
- R11: A configuration write to the channel-mode register (cfgSel 3) or the global enable (cfgSel 4) truncates xferCount to its low 24 bits. The other configuration selects are 0 source and 1 destination, which load memAddr, and 2 count.
- R12: hostReady is 0 while a drain is pending or running. Host writes offered while it is low are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostSel | input | 2 | Host register select: 0 control, 1 length, 2 data port |
| hostWrData | input | 16 | Host write data |
| hostReady | output | 1 | Host write accepted when high |
| xferEnable | output | 1 | Transfer-enable bit of the control register |
| modeBit | output | 1 | Stored mode bit of the control register |
| fifoFull | output | 1 | FIFO full status |
| lengthLeft | output | 16 | Host-side remaining length |
| cfgWrEn | input | 1 | DMA configuration write strobe |
| cfgSel | input | 3 | 0 source, 1 destination, 2 count, 3 channel mode, 4 global enable |
| cfgWrData | input | 32 | Configuration write data |
| srcAddr | output | 32 | Source address register |
| xferCount | output | 32 | DMA transfer count |
| chanCtrl | output | 32 | Channel-mode register, bit 1 is the end flag |
| memValid | output | 1 | Memory write request |
| memReady | input | 1 | Memory accepts the write |
| memAddr | output | 32 | Write address, the current destination |
| memData | output | 16 | Write data |

## Verification
Each burst of four words is run against a memory port that accepts every cycle, one that stalls some cycles, and one that is held off entirely. These show whether the data order, the address step and the hold under back-pressure are right. A fifth word pushed into a full FIFO, a word pushed before the enable is set, and pairs of words short of a group show apart writes that are discarded or that do not start a drain from ones that do. A full FIFO with the channel mode reading 2'b11, and a drain started with a zero transfer count, separate the mode-match condition and the flush-on-zero-count stop from the ordinary burst. The final bursts run the host length down to zero, and they show that each side completes on its own.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  localparam logic [1:0] HOST_CTRL = 2'd0;
  localparam logic [1:0] HOST_LEN  = 2'd1;
  localparam logic [1:0] HOST_DATA = 2'd2;

  localparam logic [2:0] CFG_SRC    = 3'd0;
  localparam logic [2:0] CFG_DST    = 3'd1;
  localparam logic [2:0] CFG_COUNT  = 3'd2;
  localparam logic [2:0] CFG_CHAN   = 3'd3;
  localparam logic [2:0] CFG_GLOBAL = 3'd4;

  typedef struct packed {
    logic pushWord;
    logic popWord;
    logic finish;
    logic draining;
  } dreqStrobe_t;
endpackage

// File: rtl/dreq_ctrl.sv
module dreq_ctrl
  import dreq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [1:0]  hostSel,
  input  logic        xferEnable,
  input  logic        fifoFull,
  input  logic        drainArmed,
  input  logic        stopNow,
  input  logic        memReady,
  output logic        memValid,
  output logic        hostReady,
  output dreqStrobe_t stb
);
  typedef enum logic {ST_IDLE, ST_DRAIN} state_t;
  state_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (drainArmed) state <= ST_DRAIN;
        ST_DRAIN: if (stopNow)    state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.draining = (state == ST_DRAIN);
    hostReady    = !stb.draining && !drainArmed;
    memValid     = stb.draining && !stopNow;
    stb.popWord  = memValid && memReady;
    stb.finish   = stb.draining && stopNow;
    stb.pushWord = hostWrEn && hostReady && (hostSel == HOST_DATA)
                   && xferEnable && !fifoFull;
  end
endmodule

// File: rtl/dreq_datapath.sv
module dreq_datapath
  import dreq_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int DW       = 16,
  parameter int AW       = 32,
  parameter int CNT_BITS = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  dreqStrobe_t   stb,
  input  logic          hostWrEn,
  input  logic          hostReady,
  input  logic [1:0]    hostSel,
  input  logic [DW-1:0] hostWrData,
  input  logic          cfgWrEn,
  input  logic [2:0]    cfgSel,
  input  logic [AW-1:0] cfgWrData,
  output logic          xferEnable,
  output logic          modeBit,
  output logic          fifoFull,
  output logic [DW-1:0] lengthLeft,
  output logic [AW-1:0] srcAddr,
  output logic [AW-1:0] dstAddr,
  output logic [AW-1:0] xferCount,
  output logic [AW-1:0] chanCtrl,
  output logic          drainArmed,
  output logic          stopNow,
  output logic [DW-1:0] memData
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [DW-1:0] fifoMem [DEPTH];
  logic [CW-1:0] wordCount;
  logic [CW-1:0] rdIdx;
  logic          globalOn;
  logic [AW-1:0] tcrNext;
  logic          hostWr;

  assign hostWr     = hostWrEn && hostReady;
  assign fifoFull   = (wordCount == DEPTH_C);
  assign drainArmed = (wordCount != '0) && (wordCount[1:0] == 2'b00)
                      && (chanCtrl[1:0] == 2'b01) && globalOn;
  assign stopNow    = (rdIdx == wordCount) || (xferCount == '0);
  assign memData    = fifoMem[IW'(rdIdx)];
  assign tcrNext    = stb.popWord ? xferCount - 1'b1 : xferCount;

  always_ff @(posedge clk) begin
    if (stb.pushWord) fifoMem[IW'(wordCount)] <= hostWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCount <= '0;
      rdIdx     <= '0;
    end else if (stb.finish) begin
      wordCount <= '0;
      rdIdx     <= '0;
    end else begin
      if (stb.pushWord) wordCount <= wordCount + 1'b1;
      if (stb.popWord)  rdIdx     <= rdIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferEnable <= 1'b0;
      modeBit    <= 1'b0;
      lengthLeft <= '0;
    end else begin
      if (hostWr && hostSel == HOST_CTRL) begin
        xferEnable <= hostWrData[2];
        modeBit    <= hostWrData[0];
      end else if (stb.finish && lengthLeft == '0) begin
        xferEnable <= 1'b0;
      end
      if (hostWr && hostSel == HOST_LEN)
        lengthLeft <= {hostWrData[DW-1:2], 2'b00};
      else if (stb.popWord && lengthLeft != '0)
        lengthLeft <= lengthLeft - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr   <= '0;
      dstAddr   <= '0;
      xferCount <= '0;
      chanCtrl  <= '0;
      globalOn  <= 1'b0;
    end else begin
      if (cfgWrEn && cfgSel == CFG_SRC) srcAddr <= cfgWrData;
      if (cfgWrEn && cfgSel == CFG_DST)      dstAddr <= cfgWrData;
      else if (stb.popWord)                  dstAddr <= dstAddr + AW'(2);
      if (cfgWrEn && cfgSel == CFG_COUNT)
        xferCount <= cfgWrData;
      else if (cfgWrEn && (cfgSel == CFG_CHAN || cfgSel == CFG_GLOBAL))
        xferCount <= {{(AW-CNT_BITS){1'b0}}, tcrNext[CNT_BITS-1:0]};
      else
        xferCount <= tcrNext;
      if (cfgWrEn && cfgSel == CFG_GLOBAL) globalOn <= cfgWrData[0];
      if (cfgWrEn && cfgSel == CFG_CHAN)   chanCtrl <= cfgWrData;
      if (stb.finish && xferCount == '0)   chanCtrl[1] <= 1'b1;
    end
  end
endmodule

// File: rtl/dreq_bridge.sv
module dreq_bridge
  import dreq_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int DW       = 16,
  parameter int AW       = 32,
  parameter int CNT_BITS = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWrEn,
  input  logic [1:0]    hostSel,
  input  logic [DW-1:0] hostWrData,
  output logic          hostReady,
  output logic          xferEnable,
  output logic          modeBit,
  output logic          fifoFull,
  output logic [DW-1:0] lengthLeft,
  input  logic          cfgWrEn,
  input  logic [2:0]    cfgSel,
  input  logic [AW-1:0] cfgWrData,
  output logic [AW-1:0] srcAddr,
  output logic [AW-1:0] xferCount,
  output logic [AW-1:0] chanCtrl,
  output logic          memValid,
  input  logic          memReady,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memData
);
  dreqStrobe_t stb;
  logic drainArmed;
  logic stopNow;

  dreq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .xferEnable(xferEnable), .fifoFull(fifoFull), .drainArmed(drainArmed),
    .stopNow(stopNow), .memReady(memReady), .memValid(memValid),
    .hostReady(hostReady), .stb(stb)
  );

  dreq_datapath #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .CNT_BITS(CNT_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWrEn(hostWrEn),
    .hostReady(hostReady), .hostSel(hostSel), .hostWrData(hostWrData),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .xferEnable(xferEnable), .modeBit(modeBit), .fifoFull(fifoFull),
    .lengthLeft(lengthLeft), .srcAddr(srcAddr), .dstAddr(memAddr),
    .xferCount(xferCount), .chanCtrl(chanCtrl), .drainArmed(drainArmed),
    .stopNow(stopNow), .memData(memData)
  );
endmodule

// File: rtl/dreq_bridge_checker.sv
module dreq_bridge_checker #(
  parameter int DW = 16,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          hostWrEn,
  input logic [1:0]    hostSel,
  input logic          hostReady,
  input logic [DW-1:0] lengthLeft,
  input logic          cfgWrEn,
  input logic [AW-1:0] xferCount,
  input logic [AW-1:0] chanCtrl,
  input logic          memValid,
  input logic          memReady,
  input logic [AW-1:0] memAddr
);
  AST_LEN_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn && hostReady && hostSel == 2'd1 |=> lengthLeft[1:0] == 2'b00); // R3

  AST_STALL_IN_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !hostReady); // R12

  AST_DST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memReady && !cfgWrEn |=> memAddr == $past(memAddr) + AW'(2)); // R7

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady && !cfgWrEn |=> memValid && $stable(memAddr)); // R7

  AST_END_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostReady) && !$past(cfgWrEn) && xferCount == '0 |-> chanCtrl[1]); // R10
endmodule

bind dreq_bridge dreq_bridge_checker #(.DW(DW), .AW(AW)) u_checker (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
  .hostReady(hostReady), .lengthLeft(lengthLeft), .cfgWrEn(cfgWrEn),
  .xferCount(xferCount), .chanCtrl(chanCtrl), .memValid(memValid),
  .memReady(memReady), .memAddr(memAddr)
);

// File: tb/dreq_bridge_tb.sv
module dreq_bridge_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [1:0]  hostSel = '0;
  logic [15:0] hostWrData = '0;
  logic        hostReady, xferEnable, modeBit, fifoFull;
  logic [15:0] lengthLeft;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] srcAddr, xferCount, chanCtrl, memAddr;
  logic        memValid;
  logic        memReady = 1'b0;
  logic [15:0] memData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int readyMode = 0;   // 0 always, 1 stall pattern, 2 held low
  int cyc = 0;
  logic [31:0] expDst = 32'h1000;
  logic [47:0] expQ[$];

  always #10 clk = ~clk;

  dreq_bridge u_dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostReady(hostReady), .xferEnable(xferEnable),
    .modeBit(modeBit), .fifoFull(fifoFull), .lengthLeft(lengthLeft),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .srcAddr(srcAddr), .xferCount(xferCount), .chanCtrl(chanCtrl),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memData(memData)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 memReady <= (readyMode == 0) ? 1'b1 : (readyMode == 1) ? (cyc % 3 != 0) : 1'b0;
  end

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected memory writes as the design produces them
  always @(negedge clk) begin
    if (rstN && !finished && memValid && memReady) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: actual write %h@%h expected none", memData, memAddr);
      end else begin
        logic [47:0] e;
        e = expQ.pop_front();
        check("R7 scoreboard", {memAddr, memData}, e);
      end
    end
  end

  task automatic hostWrite(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    while (!hostReady) @(negedge clk);
    hostWrEn = 1'b1; hostSel = sel; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  // driver: pushes a word and, when it should drain, its expected write
  task automatic pushWord(input logic [15:0] d, input bit expectOut);
    hostWrite(2'd2, d);
    if (expectOut) begin
      expQ.push_back({expDst, d});
      expDst += 32'd2;
    end
  endtask

  task automatic cfgWrite(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!hostReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {xferEnable, modeBit, fifoFull, memValid, hostReady}, 5'b00001);
    check("R1 len/count/chan", {lengthLeft, xferCount}, 48'h0);
    check("R1 chanCtrl", chanCtrl, 0);

    cfgWrite(3'd1, 32'h1000);
    cfgWrite(3'd0, 32'h2000_4012);
    check("R11 src", srcAddr, 32'h2000_4012);
    cfgWrite(3'd2, 32'h0300_0008);
    cfgWrite(3'd3, 32'h1);
    check("R11 truncate", xferCount, 32'h8);
    cfgWrite(3'd4, 32'h1);

    // R4: data write before enable is dropped (would break scoreboard order)
    pushWord(16'hDEAD, 0);
    check("R4 ignored", {fifoFull, memValid}, 2'b00);
    hostWrite(2'd1, 16'h0013);
    check("R3 length", lengthLeft, 16'h0010);
    hostWrite(2'd0, 16'h0005);
    check("R2 ctrl 5", {xferEnable, modeBit}, 2'b11);
    hostWrite(2'd0, 16'h0004);
    check("R2 ctrl 4", {xferEnable, modeBit}, 2'b10);

    // Burst A: memory held off, then released
    readyMode = 2;
    for (int i = 0; i < 4; i++) pushWord(16'hA000 + 16'(i), 1);
    repeat (3) @(negedge clk);
    check("R12 stall", {memValid, hostReady}, 2'b10);
    hostWrEn = 1'b1; hostSel = 2'd1; hostWrData = 16'h00F0;
    @(negedge clk);
    hostWrEn = 1'b0;
    readyMode = 1;
    waitIdle();
    check("R12 write not taken", lengthLeft, 16'd12);
    check("R7 count", xferCount, 32'd4);
    check("R8 after A", {fifoFull, xferEnable, chanCtrl[1]}, 3'b010);

    // Burst B: fill while globally disabled, overflow word dropped
    readyMode = 0;
    cfgWrite(3'd4, 32'h0);
    for (int i = 0; i < 4; i++) pushWord(16'hB000 + 16'(i), 1);
    pushWord(16'hBFFF, 0);
    repeat (3) @(negedge clk);
    check("R5 full", {fifoFull, memValid}, 2'b10);
    cfgWrite(3'd4, 32'h1);
    waitIdle();
    check("R10 end flag", {xferCount, 15'd0, chanCtrl[1]}, 48'h1);
    check("R9 not yet", {lengthLeft, 15'd0, xferEnable}, {16'd8, 16'd1});
    check("R8 empty", fifoFull, 0);

    // C: mode 2'b11 blocks drain; zero count then flushes
    for (int i = 0; i < 4; i++) pushWord(16'hC000 + 16'(i), 0);
    repeat (4) @(negedge clk);
    check("R6 mode mismatch", {fifoFull, memValid, hostReady}, 3'b101);
    cfgWrite(3'd3, 32'h1);
    waitIdle();
    check("R8 flush", {fifoFull, chanCtrl[1:0]}, 3'b011);
    check("R8 length kept", lengthLeft, 16'd8);

    // D: partial group waits; two bursts exhaust host length
    cfgWrite(3'd2, 32'h10);
    cfgWrite(3'd3, 32'h1);
    for (int i = 0; i < 2; i++) pushWord(16'hD000 + 16'(i), 1);
    repeat (4) @(negedge clk);
    check("R6 partial group", {memValid, hostReady}, 2'b01);
    for (int i = 2; i < 4; i++) pushWord(16'hD000 + 16'(i), 1);
    waitIdle();
    check("R7 length", lengthLeft, 16'd4);
    for (int i = 0; i < 4; i++) pushWord(16'hE000 + 16'(i), 1);
    waitIdle();
    check("R9 enable cleared", {lengthLeft, 15'd0, xferEnable}, 32'h0);
    check("R7 count D", xferCount, 32'd8);
    pushWord(16'hF00D, 0);
    repeat (3) @(negedge clk);
    check("R4 after end", {fifoFull, memValid}, 2'b00);
    check("R8 all sent", 48'(expQ.size()), 48'd0);
    finishRun();
  end
endmodule